// File: doc/BRIEF.md
# Rotating Priority One-Hot Arbiter

This block picks one requester out of a vector of request flags. The caller supplies the current priority position as an index. The block looks at that position first. It then searches upward through the higher positions, and after the top bit it wraps back to bit 0. The first position it finds with its flag set is marked in a one-hot grant vector.

The block is purely combinational. When no flag is set, the grant is all zeros and a separate idle output is raised. Internally the request vector is rotated so that the priority position lands at bit 0. A lowest-bit-first picker then isolates one bit, and the result is rotated back into place. A surrounding controller keeps and advances the index. That update is not part of this block.

Top module: `rotating_arbiter`

## Requirements
- R1: The grant output has at most one bit set for every input combination.
- R2: The idle output is 1 exactly when the request vector is all zeros, and then the grant is all zeros. Otherwise idle is 0 and exactly one grant bit is set.
- R3: A grant bit is set only at a position whose request bit is set.
- R4: When the index is in range and the request bit at the index is set, that same position is granted.
- R5: The grant goes to the first requesting position met when searching from the index upward, wrapping from bit N-1 to bit 0. With requests 10'b0000111101 and index 1 the grant is 10'b0000000100. With index 6 the grant is 10'b0000000001.
- R6: An index value of N or larger behaves exactly like index 0.
- R7: The default configuration has 10 request bits, a 4-bit index and a 10-bit grant, with bit i of each vector standing for requester i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req | input | N (10) | Request flags, bit i for requester i |
| prio_idx | input | $clog2(N) (4) | Position searched first |
| grant | output | N (10) | One-hot grant, bit i for requester i |
| idle | output | 1 | High when no request is set |

## Verification
Every result of this block is due in the same cycle as its stimulus, because no register lies between the inputs and the outputs. The bench changes the inputs on the falling clock edge. It then waits one nanosecond for the logic to settle before it compares grant and idle against a loop model, so no check depends on the order of events at a rising edge. All 1024 request patterns are swept against all 16 index codes, which covers both the wrap cases and the out-of-range index codes.

// File: rtl/rarb_pkg.sv
package rarb_pkg;
  typedef enum logic {ROT_RIGHT = 1'b0, ROT_LEFT = 1'b1} rot_dir_e;
endpackage

// File: rtl/rarb_rotate.sv
module rarb_rotate
  import rarb_pkg::*;
#(
  parameter int       N   = 10,
  parameter rot_dir_e DIR = ROT_RIGHT,
  localparam int      IW  = $clog2(N)
) (
  input  logic [N-1:0]  din,
  input  logic [IW-1:0] amt,
  output logic [N-1:0]  dout
);
  localparam int DW = 2 * N;
  logic [DW-1:0] dbl;
  logic [DW-1:0] shifted;

  assign dbl = {din, din};

  generate
    if (DIR == ROT_RIGHT) begin : g_right
      // bit i of the result takes din[(i + amt) mod N]
      assign shifted = dbl >> amt;
      assign dout    = shifted[N-1:0];
    end else begin : g_left
      // bit i of the result takes din[(i - amt) mod N]
      assign shifted = dbl << amt;
      assign dout    = shifted[DW-1:N];
    end
  endgenerate
endmodule

// File: rtl/rarb_lowest_pick.sv
module rarb_lowest_pick #(
  parameter int N = 10
) (
  input  logic [N-1:0] din,
  output logic [N-1:0] onehot,
  output logic         empty
);
  always_comb begin
    onehot = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (din[i]) onehot = N'(1) << i;
    end
  end
  assign empty = ~|din;
endmodule

// File: rtl/rotating_arbiter.sv
module rotating_arbiter
  import rarb_pkg::*;
#(
  parameter int  N  = 10,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] prio_idx,
  output logic [N-1:0]  grant,
  output logic          idle
);
  logic [IW-1:0] start_pos;
  logic [N-1:0]  aligned;
  logic [N-1:0]  picked;

  // indices past the last requester fold to position 0
  assign start_pos = ({1'b0, prio_idx} >= (IW+1)'(N)) ? '0 : prio_idx;

  rarb_rotate #(.N(N), .DIR(ROT_RIGHT)) u_align (
    .din (req),
    .amt (start_pos),
    .dout(aligned)
  );

  rarb_lowest_pick #(.N(N)) u_pick (
    .din   (aligned),
    .onehot(picked),
    .empty (idle)
  );

  rarb_rotate #(.N(N), .DIR(ROT_LEFT)) u_restore (
    .din (picked),
    .amt (start_pos),
    .dout(grant)
  );
endmodule

// File: rtl/rotating_arbiter_chk.sv
module rotating_arbiter_chk #(
  parameter int  N  = 10,
  localparam int IW = $clog2(N)
) (
  input logic [N-1:0]  req,
  input logic [IW-1:0] prio_idx,
  input logic [N-1:0]  grant,
  input logic          idle
);
  always_comb begin
    assert_grant_onehot0_R1: assert ($onehot0(grant));
    assert_idle_matches_req_R2: assert (idle == (req == '0));
    assert_grant_present_R2: assert (idle || $countones(grant) == 1);
    assert_grant_is_requested_R3: assert ((grant & ~req) == '0);
    if (int'(prio_idx) < N) begin
      if (req[int'(prio_idx)]) begin
        assert_index_first_R4: assert (grant[int'(prio_idx)]);
      end
    end else begin
      if (req[0]) begin
        assert_oob_index_is_zero_R6: assert (grant[0]);
      end
    end
  end
endmodule

bind rotating_arbiter rotating_arbiter_chk #(.N(N)) u_chk (
  .req     (req),
  .prio_idx(prio_idx),
  .grant   (grant),
  .idle    (idle)
);

// File: tb/rotating_arbiter_bench.sv
`timescale 1ns/1ps
module rotating_arbiter_bench;
  localparam int N  = 10;
  localparam int IW = $clog2(N);

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  req;
  logic [IW-1:0] prio_idx;
  logic [N-1:0]  grant;
  logic          idle;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  rotating_arbiter #(.N(N)) u_rotating_arbiter (
    .req     (req),
    .prio_idx(prio_idx),
    .grant   (grant),
    .idle    (idle)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [N-1:0] model_grant(logic [N-1:0] v, int ix);
    int s = (ix >= N) ? 0 : ix;
    for (int k = 0; k < N; k++) begin
      int p = (s + k) % N;
      if (v[p]) return N'(1) << p;
    end
    return '0;
  endfunction

  task automatic check(string tag, logic [N:0] got, logic [N:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got %b expected %b (req=%b idx=%0d)",
               tag, got, exp, req, prio_idx);
    end
  endtask

  // drive away from the rising edge, settle, then compare in the same cycle
  task automatic apply(logic [N-1:0] v, int ix);
    @(negedge clk);
    req      = v;
    prio_idx = IW'(ix);
    #1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; req = '0; prio_idx = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    apply('0, 0);
    check("R2 reset idle", {idle, grant}, {1'b1, {N{1'b0}}});
  endtask

  task automatic t_examples;
    apply(10'b0000111101, 1);
    check("R5 R7 example idx1", {idle, grant}, {1'b0, 10'b0000000100});
    apply(10'b0000111101, 6);
    check("R5 R7 example idx6 wrap", {idle, grant}, {1'b0, 10'b0000000001});
  endtask

  task automatic t_index_valid;
    apply(10'b1111111111, 7);
    check("R4 idx valid", {1'b0, grant}, {1'b0, 10'b0010000000});
    apply(10'b1000000000, 9);
    check("R4 top idx valid", {1'b0, grant}, {1'b0, 10'b1000000000});
  endtask

  task automatic t_wrap;
    apply(10'b0000000010, 9);
    check("R5 wrap from top", {1'b0, grant}, {1'b0, 10'b0000000010});
    apply(10'b0000010000, 5);
    check("R5 full wrap to below idx", {1'b0, grant}, {1'b0, 10'b0000010000});
  endtask

  task automatic t_out_of_range;
    apply(10'b0100000100, 12);
    check("R6 idx 12 like 0", {1'b0, grant}, {1'b0, 10'b0000000100});
    apply(10'b1000000001, 15);
    check("R6 idx 15 like 0", {1'b0, grant}, {1'b0, 10'b0000000001});
  endtask

  task automatic t_exhaustive;
    for (int v = 0; v < (1 << N); v++) begin
      for (int ix = 0; ix < (1 << IW); ix++) begin
        logic [N-1:0] e;
        apply(N'(v), ix);
        e = model_grant(N'(v), ix);
        check("R1 R2 R3 R5 sweep", {idle, grant}, {(v == 0), e});
      end
    end
  endtask

  initial begin
    #(200_000 * 10);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_examples();
    t_index_valid();
    t_wrap();
    t_out_of_range();
    t_exhaustive();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule